// File: doc/BRIEF.md
# CEC Frame Transmitter with Arbitration

This block sends one frame on a single-wire, open-drain CEC bus. The host writes up to `MAX_BYTES` bytes into a small buffer, then pulses `start` together with a frame length and a signal-free time given in whole bit periods. The block watches the line until it has stayed high long enough. It then drives a start bit and sends each byte as ten bit slots. Eight of these slots carry data, one carries end-of-message and one is the acknowledge slot. The only line output is `drive_low`; when it is low the line is released and pulled high externally.

At fixed sample points the block reads the synchronized line. It uses these reads to notice that another initiator won arbitration, to read the acknowledge, and to catch a follower that holds the line low to signal an error. Each accepted transfer ends with a one-cycle `done` pulse and a 2-bit `status` code. Every timing below is counted in `tick_us` enables. The defaults assume one enable per microsecond.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset `drive_low` and `done` are 0, and no transfer is pending.
- R2: The start bit drives the line low for `T_START_LOW` ticks (default 3700), and the next falling edge comes `T_START_TOT` ticks (default 4500) after the start bit's falling edge.
- R3: A data slot drives low for `T_ONE_LOW` ticks (default 600) for a 1 and `T_ZERO_LOW` ticks (default 1500) for a 0. Consecutive slot falling edges are `T_BIT` ticks (default 2400) apart.
- R4: Each byte is sent as ten slots: bits 7 down to 0, then the end-of-message slot, then the acknowledge slot, which is always driven as a 1.
- R5: The end-of-message slot carries 1 on the final byte of the frame and 0 on every other byte.
- R6: A logical-1 among the first four slots of byte 0 is read `T_SAMPLE` ticks (default 850) after its falling edge. If the line reads low there, the block stops driving for the rest of the frame and reports code 2 (arbitration lost).
- R7: The acknowledge slot is also read at `T_SAMPLE`. A frame is broadcast when the low nibble of byte 0 equals 15. A directed frame counts as acknowledged when the line reads low, and a broadcast frame only when it reads high. When every byte is acknowledged, the transfer ends after the last acknowledge slot with code 0 (OK).
- R8: A negative acknowledge ends the transfer when that slot's bit period completes, even if bytes remain, and reports code 1 (NACK).
- R9: If the line is low at the end of a slot that was read at its sample point, the block reports code 3 (low drive). It then stays off the line until the line is high again.
- R10: A transfer begins only once the line has been continuously high for more than `free_bits` whole `T_BIT` periods.
- R11: A low level on the line while a transfer waits to begin restarts the signal-free count.
- R12: A `start` pulse is ignored when `frame_len` is 0 or above `MAX_BYTES`, or when a transfer is already pending or running. An ignored pulse produces no line activity and no `done`.
- R13: `done` is high for exactly one cycle per transfer. `status` holds its code until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | Timing enable, one per time unit |
| line_in | input | 1 | Synchronized level of the bus line |
| wr_en | input | 1 | Write strobe for the frame buffer |
| wr_addr | input | $clog2(MAX_BYTES) | Byte index to write |
| wr_data | input | 8 | Byte value to write |
| frame_len | input | $clog2(MAX_BYTES+1) | Number of bytes, sampled on start |
| free_bits | input | SFT_W | Signal-free time in bit periods, sampled on start |
| start | input | 1 | Request one transfer |
| drive_low | output | 1 | 1 pulls the line low; 0 releases it |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 NACK, 2 arbitration lost, 3 low drive |

## Verification
The assertions assume that `line_in` is already synchronized and follows `drive_low` in the cycle after it changes, as a wired-AND line does. They also assume the buffer is not rewritten while a frame is being sent. The bench models the line as the AND of the block's release and a follower that pulls low only in a slot the block has already opened. It writes the buffer only between transfers and holds `tick_us` high, so the tick count equals the cycle count. With scaled timing parameters, the bench checks every sample point and end-of-slot decision at an exact cycle.

// File: rtl/cec_tx_pkg.sv
`timescale 1ns/1ps
package cec_tx_pkg;
  typedef enum logic [1:0] {
    TX_OK     = 2'd0,
    TX_NACK   = 2'd1,
    TX_ARB    = 2'd2,
    TX_LOWDRV = 2'd3
  } tx_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_SLOT,
    ST_HOLD
  } eng_state_e;
endpackage

// File: rtl/cec_tx_buf.sv
`timescale 1ns/1ps
module cec_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cec_tx_free_timer.sv
`timescale 1ns/1ps
module cec_tx_free_timer #(
  parameter int T_BIT = 2400,
  parameter int PER_W = 5,
  localparam int SUB_W = $clog2(T_BIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line_in,
  output logic [PER_W-1:0] periods
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(T_BIT - 1);
  localparam logic [PER_W-1:0] PER_MAX  = '1;

  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || !line_in) begin
      sub     <= '0;
      periods <= '0;
    end else if (tick) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (periods != PER_MAX) periods <= periods + PER_W'(1);
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  // R11: a low line clears the accumulated free time
  a_r11_low_clears: assert property (@(posedge clk) disable iff (rst)
    !line_in |=> (periods == '0));
endmodule

// File: rtl/cec_tx_engine.sv
`timescale 1ns/1ps
module cec_tx_engine
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES   = 16,
  parameter int SFT_W       = 4,
  parameter int T_START_LOW = 3700,
  parameter int T_START_TOT = 4500,
  parameter int T_ZERO_LOW  = 1500,
  parameter int T_ONE_LOW   = 600,
  parameter int T_BIT       = 2400,
  parameter int T_SAMPLE    = 850,
  localparam int AW    = $clog2(MAX_BYTES),
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int PER_W = SFT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line_in,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [SFT_W-1:0] free_bits,
  input  logic [PER_W-1:0] free_per,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             drive_low,
  output logic             done,
  output tx_status_e       status
);
  localparam int CNT_TOP = (T_START_TOT > T_BIT) ? T_START_TOT : T_BIT;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] C_START_LOW = CNT_W'(T_START_LOW);
  localparam logic [CNT_W-1:0] C_START_TOT = CNT_W'(T_START_TOT);
  localparam logic [CNT_W-1:0] C_ZERO      = CNT_W'(T_ZERO_LOW);
  localparam logic [CNT_W-1:0] C_ONE       = CNT_W'(T_ONE_LOW);
  localparam logic [CNT_W-1:0] C_BIT       = CNT_W'(T_BIT);
  localparam logic [CNT_W-1:0] C_SAMPLE    = CNT_W'(T_SAMPLE);
  localparam logic [LEN_W-1:0] LEN_MAX     = LEN_W'(MAX_BYTES);

  eng_state_e       state;
  logic             pending;
  logic [LEN_W-1:0] len_q;
  logic [SFT_W-1:0] sft_q;
  logic [7:0]       shreg;
  logic [AW-1:0]    byte_idx;
  logic [3:0]       slot;
  logic [CNT_W-1:0] cnt;
  logic             bcast_q;
  logic             nack_q;

  logic [CNT_W-1:0] cnt_nx;
  logic             last_byte, bit_val, sampled, len_ok;
  logic [CNT_W-1:0] low_len;
  logic [PER_W-1:0] sft_ext;

  always_comb begin
    cnt_nx    = cnt + CNT_W'(1);
    last_byte = (LEN_W'(byte_idx) == len_q - LEN_W'(1));
    if (slot < 4'd8)       bit_val = shreg[7];
    else if (slot == 4'd8) bit_val = last_byte;
    else                   bit_val = 1'b1;
    sampled = bit_val && (((byte_idx == '0) && (slot < 4'd4)) || (slot == 4'd9));
    low_len = bit_val ? C_ONE : C_ZERO;
    len_ok  = (frame_len != '0) && (frame_len <= LEN_MAX);
    sft_ext = PER_W'(sft_q);
  end

  assign rd_addr = (state == ST_IDLE) ? '0 : byte_idx + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      len_q     <= '0;
      sft_q     <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      slot      <= '0;
      cnt       <= '0;
      bcast_q   <= 1'b0;
      nack_q    <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      status    <= TX_OK;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!pending) begin
            if (start && len_ok) begin
              pending <= 1'b1;
              len_q   <= frame_len;
              sft_q   <= free_bits;
            end
          end else if (line_in && (free_per > sft_ext)) begin
            pending   <= 1'b0;
            state     <= ST_START;
            drive_low <= 1'b1;
            cnt       <= '0;
            shreg     <= rd_data;
            bcast_q   <= (rd_data[3:0] == 4'hF);
            byte_idx  <= '0;
            slot      <= '0;
            nack_q    <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            cnt <= cnt_nx;
            if (cnt_nx == C_START_LOW) drive_low <= 1'b0;
            if (cnt_nx == C_START_TOT) begin
              state     <= ST_SLOT;
              cnt       <= '0;
              drive_low <= 1'b1;
            end
          end
        end
        ST_SLOT: begin
          if (tick) begin
            cnt <= cnt_nx;
            if (cnt_nx == low_len) drive_low <= 1'b0;
            if ((cnt_nx == C_SAMPLE) && sampled) begin
              if (slot != 4'd9 && !line_in) begin
                state     <= ST_IDLE;
                drive_low <= 1'b0;
                done      <= 1'b1;
                status    <= TX_ARB;
              end else if (slot == 4'd9) begin
                nack_q <= bcast_q ? !line_in : line_in;
              end
            end
            if (cnt_nx == C_BIT) begin
              if (sampled && !line_in) begin
                state  <= ST_HOLD;
                done   <= 1'b1;
                status <= TX_LOWDRV;
              end else if (nack_q) begin
                state  <= ST_IDLE;
                done   <= 1'b1;
                status <= TX_NACK;
              end else if (slot == 4'd9 && last_byte) begin
                state  <= ST_IDLE;
                done   <= 1'b1;
                status <= TX_OK;
              end else begin
                cnt       <= '0;
                drive_low <= 1'b1;
                if (slot == 4'd9) begin
                  slot     <= '0;
                  byte_idx <= byte_idx + AW'(1);
                  shreg    <= rd_data;
                end else begin
                  slot <= slot + 4'd1;
                  if (slot < 4'd8) shreg <= {shreg[6:0], 1'b0};
                end
              end
            end
          end
        end
        ST_HOLD: begin
          if (line_in) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: completion is a single-cycle pulse
  a_r13_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: after losing arbitration the line is released
  a_r6_release_on_arb: assert property (@(posedge clk) disable iff (rst)
    (done && status == TX_ARB) |-> !drive_low);

  // R10: the start bit begins only after enough free time
  a_r10_free_before_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && $past(state) == ST_IDLE) |-> ($past(free_per) > $past(sft_ext)));

  // R3: a data slot never holds the line longer than a zero
  a_r3_low_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLOT && drive_low) |-> (cnt < C_ZERO));

  // R9: while waiting out a low drive the block stays off the line
  a_r9_hold_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> !drive_low);
endmodule

// File: rtl/cec_frame_tx.sv
`timescale 1ns/1ps
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES   = 16,
  parameter int SFT_W       = 4,
  parameter int T_START_LOW = 3700,
  parameter int T_START_TOT = 4500,
  parameter int T_ZERO_LOW  = 1500,
  parameter int T_ONE_LOW   = 600,
  parameter int T_BIT       = 2400,
  parameter int T_SAMPLE    = 850,
  localparam int AW    = $clog2(MAX_BYTES),
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int PER_W = SFT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_us,
  input  logic             line_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [SFT_W-1:0] free_bits,
  input  logic             start,
  output logic             drive_low,
  output logic             done,
  output logic [1:0]       status
);
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;
  logic [PER_W-1:0] free_per;
  tx_status_e       status_e;

  cec_tx_buf #(.DEPTH(MAX_BYTES), .DW(8)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  cec_tx_free_timer #(.T_BIT(T_BIT), .PER_W(PER_W)) u_free (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_us),
    .line_in (line_in),
    .periods (free_per)
  );

  cec_tx_engine #(
    .MAX_BYTES(MAX_BYTES), .SFT_W(SFT_W),
    .T_START_LOW(T_START_LOW), .T_START_TOT(T_START_TOT),
    .T_ZERO_LOW(T_ZERO_LOW), .T_ONE_LOW(T_ONE_LOW),
    .T_BIT(T_BIT), .T_SAMPLE(T_SAMPLE)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_us),
    .line_in   (line_in),
    .start     (start),
    .frame_len (frame_len),
    .free_bits (free_bits),
    .free_per  (free_per),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .drive_low (drive_low),
    .done      (done),
    .status    (status_e)
  );

  assign status = status_e;
endmodule

// File: tb/test_cec_frame_tx.sv
`timescale 1ns/1ps
module test_cec_frame_tx;
  localparam int SL  = 370;
  localparam int ST  = 450;
  localparam int Z   = 150;
  localparam int O   = 60;
  localparam int B   = 240;
  localparam int SMP = 85;

  typedef struct packed {
    logic [4:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic [1:0] mode;
    logic [1:0] arg;
    logic [1:0] st;
    logic [5:0] np;
  } vec_t;

  // modes: 0 silent follower, 1 ack every byte, 2 pull in data slot arg, 3 long low in first ack
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'd1, 8'h4F, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 6'd11},
    '{5'd2, 8'h40, 8'h36, 8'h00, 2'd1, 2'd0, 2'd0, 6'd21},
    '{5'd3, 8'h15, 8'h9A, 8'hC3, 2'd1, 2'd0, 2'd0, 6'd31},
    '{5'd2, 8'h40, 8'h36, 8'h00, 2'd0, 2'd0, 2'd1, 6'd11},
    '{5'd2, 8'h4F, 8'h84, 8'h00, 2'd1, 2'd0, 2'd1, 6'd11},
    '{5'd1, 8'h40, 8'h00, 8'h00, 2'd2, 2'd1, 2'd2, 6'd3},
    '{5'd2, 8'hE5, 8'h11, 8'h00, 2'd2, 2'd2, 2'd2, 6'd4},
    '{5'd2, 8'h40, 8'h36, 8'h00, 2'd3, 2'd0, 2'd3, 6'd11}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] frame_len = '0;
  logic [3:0] free_bits = '0;
  logic       start = 1'b0;
  logic       bench_pull = 1'b0;
  logic       drive_low, done;
  logic [1:0] status;
  logic       line_in;
  logic       resp_low;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int npul = 0;
  int ndone = 0;
  int fall_t [64];
  int wid [64];
  int resp_cnt = 0;
  logic prev_drv = 1'b0;
  logic mon_clr = 1'b0;
  logic [1:0] rmode = '0;
  logic [1:0] rarg = '0;

  always #2.5 clk = ~clk;

  assign resp_low = (resp_cnt != 0);
  assign line_in  = !(drive_low || resp_low || bench_pull);

  cec_frame_tx #(
    .MAX_BYTES(16), .SFT_W(4),
    .T_START_LOW(SL), .T_START_TOT(ST), .T_ZERO_LOW(Z),
    .T_ONE_LOW(O), .T_BIT(B), .T_SAMPLE(SMP)
  ) i_cec_frame_tx (
    .clk(clk), .rst(rst), .tick_us(1'b1), .line_in(line_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_len(frame_len), .free_bits(free_bits), .start(start),
    .drive_low(drive_low), .done(done), .status(status)
  );

  // line monitor and follower model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_drv <= drive_low;
    if (done) ndone <= ndone + 1;
    if (resp_cnt != 0) resp_cnt <= resp_cnt - 1;
    if (mon_clr) begin
      npul <= 0;
    end else begin
      if (drive_low && !prev_drv && npul < 64) begin
        fall_t[npul] <= cyc;
        npul <= npul + 1;
        if (npul >= 1) begin
          if (rmode == 2'd1 && ((npul - 1) % 10) == 9) resp_cnt <= Z;
          if (rmode == 2'd2 && (npul - 1) == int'(rarg)) resp_cnt <= Z;
          if (rmode == 2'd3 && (npul - 1) == 9) resp_cnt <= (3 * B) / 2;
        end
      end
      if (!drive_low && prev_drv && npul >= 1) wid[npul-1] <= cyc - fall_t[npul-1];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_start(input int len, input int sft);
    @(negedge clk); start = 1'b1; frame_len = 5'(len); free_bits = 4'(sft);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int limit, output bit got, output logic [1:0] st);
    got = 1'b0; st = '0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; st = status; end
    end
    if (got) begin
      @(negedge clk);
      chk(!done, "R13 done width", int'(done), 0);
      repeat (4) @(negedge clk);
      chk(status == st, "R13 status held", int'(status), int'(st));
    end
  endtask

  function automatic string st_req(input logic [1:0] s);
    case (s)
      2'd0: return "R7 status";
      2'd1: return "R8 status";
      2'd2: return "R6 status";
      default: return "R9 status";
    endcase
  endfunction

  // compare recorded pulses with the frame content (R2 R3 R4 R5)
  task automatic check_content(input vec_t v);
    bit ok = 1'b1;
    int act = 0, exp = 0;
    logic [7:0] bytes [3];
    bytes[0] = v.b0; bytes[1] = v.b1; bytes[2] = v.b2;
    if (wid[0] != SL) begin ok = 1'b0; act = wid[0]; exp = SL; end
    if (ok && npul > 1 && (fall_t[1] - fall_t[0]) != ST) begin
      ok = 1'b0; act = fall_t[1] - fall_t[0]; exp = ST;
    end
    for (int i = 1; i < npul && ok; i++) begin
      int s = (i - 1) % 10;
      int b = (i - 1) / 10;
      logic bv;
      if (s < 8)       bv = bytes[b][7 - s];
      else if (s == 8) bv = (b == int'(v.len) - 1);
      else             bv = 1'b1;
      if (wid[i] != (bv ? O : Z)) begin ok = 1'b0; act = wid[i]; exp = bv ? O : Z; end
      if (ok && i + 1 < npul && (fall_t[i+1] - fall_t[i]) != B) begin
        ok = 1'b0; act = fall_t[i+1] - fall_t[i]; exp = B;
      end
    end
    chk(ok, "R2/R3/R4/R5 waveform", act, exp);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      begin
        bit got;
        logic [1:0] st;
        int base, d0;
        // reset state (R1)
        repeat (4) @(negedge clk);
        chk(drive_low == 1'b0, "R1 drive_low", int'(drive_low), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        @(negedge clk); rst = 1'b0;
        repeat (2 * B) @(negedge clk);
        chk(npul == 0, "R1 no pending", npul, 0);

        // vector table
        for (int k = 0; k < NV; k++) begin
          wr(0, VEC[k].b0); wr(1, VEC[k].b1); wr(2, VEC[k].b2);
          rmode = VEC[k].mode; rarg = VEC[k].arg;
          clear_mon();
          pulse_start(int'(VEC[k].len), 0);
          wait_done(20000, got, st);
          chk(got && st == VEC[k].st, st_req(VEC[k].st), int'(st), int'(VEC[k].st));
          repeat (600) @(negedge clk);
          chk(npul == int'(VEC[k].np), "R6/R8/R9 slot count", npul, int'(VEC[k].np));
          check_content(VEC[k]);
        end

        // R12: zero and oversized length ignored
        rmode = 2'd1;
        clear_mon();
        d0 = ndone;
        pulse_start(0, 0);
        repeat (1000) @(negedge clk);
        pulse_start(17, 0);
        repeat (1000) @(negedge clk);
        chk(npul == 0, "R12 bad length activity", npul, 0);
        chk(ndone == d0, "R12 bad length done", ndone - d0, 0);

        // R10: start waits for more than free_bits periods of high line
        wr(0, 8'h40);
        clear_mon();
        @(negedge clk); bench_pull = 1'b1;
        repeat (20) @(negedge clk);
        bench_pull = 1'b0; base = cyc; start = 1'b1; frame_len = 5'd1; free_bits = 4'd1;
        @(negedge clk); start = 1'b0;
        wait_done(20000, got, st);
        chk(npul > 0 && (fall_t[0] - base) >= 2 * B && (fall_t[0] - base) <= 2 * B + 4,
            "R10 free time", fall_t[0] - base, 2 * B + 1);
        chk(got && st == 2'd0, "R10 frame status", int'(st), 0);
        repeat (600) @(negedge clk);

        // R11: a low pulse while waiting restarts the count
        clear_mon();
        @(negedge clk); bench_pull = 1'b1;
        repeat (20) @(negedge clk);
        bench_pull = 1'b0; start = 1'b1; frame_len = 5'd1; free_bits = 4'd2;
        @(negedge clk); start = 1'b0;
        repeat (2 * B) @(negedge clk);
        bench_pull = 1'b1;
        repeat (20) @(negedge clk);
        bench_pull = 1'b0; base = cyc;
        wait_done(20000, got, st);
        chk(npul > 0 && (fall_t[0] - base) >= 3 * B && (fall_t[0] - base) <= 3 * B + 4,
            "R11 restart", fall_t[0] - base, 3 * B + 1);
        repeat (600) @(negedge clk);

        // R12: start during a running frame is ignored
        wr(0, 8'h40); wr(1, 8'h36);
        clear_mon();
        pulse_start(2, 0);
        repeat (2000) @(negedge clk);
        pulse_start(1, 0);
        wait_done(20000, got, st);
        chk(got && st == 2'd0, "R12 busy frame status", int'(st), 0);
        repeat (1500) @(negedge clk);
        chk(npul == 21, "R12 busy start ignored", npul, 21);
      end
      begin
        repeat (190000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule